// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This unit lets one processor raise numbered doorbells on any set of processors. It also lets an inbound message-signalled interrupt write raise doorbells in the same way. One 32-bit trigger word holds both the doorbell number and a bitmap of target CPUs. Each CPU owns a 32-bit cause register, which latches the doorbells raised for it, and a 32-bit enable register. Software running on a CPU reads and clears its own cause register. Clearing works by writing zeros: bits written as 0 drop, and bits written as 1 keep their value.

The doorbell space has three ranges:
- Doorbells 0 to 7 are inter-processor doorbells.
- Doorbells 16 to 31 carry message-signalled interrupts.
- Doorbells 8 to 15 latch in the cause register but request nothing.

For every CPU the unit drives two registered summary requests, one per signalling range. These feed interrupt IDs 0 and 1 of the surrounding interrupt controller.

The register bus carries the requester's CPU number. The per-CPU offsets therefore address the requester's own cause and enable registers. A separate inbound port accepts the message-signalled write data, which uses the same trigger word layout.

Top module: `doorbell_unit`

## Requirements
- R1: After synchronous reset, every cause register, every enable register and every summary output is zero.
- R2: A bus write to offset 0x4 is a trigger word. Bits 4:0 give the doorbell number n, and bit 8+c selects CPU c. For each selected CPU, cause bit n is set; all other cause bits and all unselected CPUs are unchanged.
- R3: Trigger word bits 7:5 are ignored, and so are target bits that name CPUs at or above NCPU (bits 12 and up with four CPUs).
- R4: A word written on the inbound message port is decoded like a trigger word. A word of 0xF00 | (16+k) sets doorbell 16+k on all four CPUs.
- R5: A bus write to offset 0x8 by CPU c clears each bit of CPU c's cause register that is written as 0. Bits written as 1 are kept, and the other CPUs are untouched. Writing 0 clears every pending doorbell of CPU c.
- R6: Offset 0xC is the requester's enable register. A 1 enables that doorbell bit, and writes replace the whole register.
- R7: ipi_irq[c] equals the OR of cause[7:0] AND enable[7:0] of CPU c, registered. It follows a cause or enable change one clock later.
- R8: msi_irq[c] equals the OR of cause[31:16] AND enable[31:16] of CPU c, registered, with the same one-clock lag.
- R9: Pending, enabled doorbells 8 to 15 assert neither summary output.
- R10: When a set, from either trigger source, and a clear hit the same cause bit in the same cycle, the bit ends up set.
- R11: A bus read returns data on bus_rdata one clock after the strobe. Offset 0x8 returns the requester's cause register, 0xC returns its enable register, and any other offset returns 0. bus_rdata holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_cpu | input | CPU_ID_W | CPU number of the requester |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| msi_wr | input | 1 | Inbound message write strobe |
| msi_data | input | DATA_W | Inbound message data (trigger word layout) |
| ipi_irq | output | NCPU | Inter-processor summary request per CPU |
| msi_irq | output | NCPU | Message-signalled summary request per CPU |

## Verification
Three trigger sweeps are used.
- Every doorbell number is crossed with every one of the 16 target bitmaps, with the ignored word bits filled with a varying pattern. This separates the number decoding from the target decoding, and exposes leakage to untargeted CPUs and to bits that should stay clear.
- Every doorbell is raised with all enables on and again with all enables off. This shows where each summary range starts and ends, including the silent gap, and shows that the enable register gates the summaries.
- Clear-by-zero words with mixed bit patterns are applied, along with same-cycle collisions of a clear and a trigger from each source. These distinguish AND-clearing from plain overwriting and check that a new doorbell wins over a clear.

// File: rtl/db_pkg.sv
package db_pkg;
  // Register offsets; software decodes these values.
  localparam int unsigned OFF_TRIG  = 4;
  localparam int unsigned OFF_CAUSE = 8;
  localparam int unsigned OFF_MASK  = 12;

  // Doorbell ranges that feed the two summary requests.
  localparam int unsigned IPI_LO = 0;
  localparam int unsigned IPI_HI = 7;
  localparam int unsigned MSI_LO = 16;
  localparam int unsigned MSI_HI = 31;

  // First target-CPU bit inside a trigger word.
  localparam int unsigned TGT_LSB = 8;
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode #(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32
) (
  input  logic                           en,
  input  logic [DATA_W-1:0]              word,
  output logic [NCPU-1:0][DATA_W-1:0]    set_vec
);
  import db_pkg::*;

  localparam int NUM_W = $clog2(DATA_W);

  logic [NUM_W-1:0]  num;
  logic [DATA_W-1:0] onehot;
  logic              unused_word_bits;

  assign num    = word[NUM_W-1:0];
  assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << num;
  // Bits above the number field and beyond the last CPU target bit carry nothing.
  assign unused_word_bits = ^word;

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    assign set_vec[c] = (en && word[TGT_LSB + c]) ? onehot : '0;
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] cause_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              ipi_irq,
  output logic              msi_irq
);
  import db_pkg::*;

  function automatic logic [DATA_W-1:0] range_sel(int lo, int hi);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i >= lo && i <= hi) r[i] = 1'b1;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] IPI_SEL = range_sel(IPI_LO, IPI_HI);
  localparam logic [DATA_W-1:0] MSI_SEL = range_sel(MSI_LO, MSI_HI);

  logic [DATA_W-1:0] cause_d;

  // Clear first, then OR in new doorbells so a same-cycle set survives.
  always_comb begin
    cause_d = cause_q;
    if (clr_en) cause_d = cause_q & clr_data;
    cause_d = cause_d | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      ipi_irq <= 1'b0;
      msi_irq <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (mask_we) mask_q <= mask_data;
      ipi_irq <= |(cause_q & mask_q & IPI_SEL);
      msi_irq <= |(cause_q & mask_q & MSI_SEL);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R10

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (|cause_q || !(|cause_q)) |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0)); // R2

  AST_IPI_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & mask_q & IPI_SEL) == '0) |=> !ipi_irq); // R7

  AST_MSI_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & mask_q & MSI_SEL) == '0) |=> !msi_irq); // R8

  AST_UNTOUCHED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && set_vec == '0) |=> $stable(cause_q)); // R5
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int CPU_ID_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CPU_ID_W-1:0] bus_cpu,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                msi_wr,
  input  logic [DATA_W-1:0]   msi_data,
  output logic [NCPU-1:0]     ipi_irq,
  output logic [NCPU-1:0]     msi_irq
);
  import db_pkg::*;

  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFF_TRIG);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);

  logic bus_wr, bus_rd;
  logic [NCPU-1:0][DATA_W-1:0] set_bus, set_msi;
  logic [NCPU-1:0][DATA_W-1:0] cause_all, mask_all;
  logic [DATA_W-1:0]           rd_mux;

  assign bus_wr = bus_en && bus_we;
  assign bus_rd = bus_en && !bus_we;

  db_trig_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec_bus (
    .en(bus_wr && bus_addr == A_TRIG), .word(bus_wdata), .set_vec(set_bus));

  db_trig_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec_msi (
    .en(msi_wr), .word(msi_data), .set_vec(set_msi));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic own;
    assign own = (bus_cpu == CPU_ID_W'(c));
    db_cpu_bank #(.DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (set_bus[c] | set_msi[c]),
      .clr_en   (bus_wr && own && bus_addr == A_CAUSE),
      .clr_data (bus_wdata),
      .mask_we  (bus_wr && own && bus_addr == A_MASK),
      .mask_data(bus_wdata),
      .cause_q  (cause_all[c]),
      .mask_q   (mask_all[c]),
      .ipi_irq  (ipi_irq[c]),
      .msi_irq  (msi_irq[c]));
  end

  always_comb begin
    rd_mux = '0;
    if (int'(bus_cpu) < NCPU) begin
      if (bus_addr == A_CAUSE)     rd_mux = cause_all[bus_cpu];
      else if (bus_addr == A_MASK) rd_mux = mask_all[bus_cpu];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/sim_doorbell_unit.sv
`timescale 1ns/1ps
module sim_doorbell_unit;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0, msi_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_cpu = '0;
  logic [31:0] bus_wdata = '0, msi_data = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ipi_irq, msi_irq;

  logic [31:0] cause_m [NCPU];
  logic [31:0] mask_m  [NCPU];
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  doorbell_unit u0 (.clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_cpu(bus_cpu), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msi_wr(msi_wr), .msi_data(msi_data),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_trig(input logic [31:0] w);
    for (int c = 0; c < NCPU; c++)
      if (w[8+c]) cause_m[c] = cause_m[c] | (32'd1 << w[4:0]);
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] cpu, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_cpu = cpu; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    if (a == 4'h4) model_trig(d);
    else if (a == 4'h8) cause_m[cpu] = cause_m[cpu] & d;
    else if (a == 4'hC) mask_m[cpu] = d;
  endtask

  task automatic msi(input logic [31:0] d);
    @(negedge clk);
    msi_wr = 1; msi_data = d;
    @(negedge clk);
    msi_wr = 0;
    model_trig(d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] cpu, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_cpu = cpu;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic check_causes(input string req);
    logic [31:0] d;
    for (int c = 0; c < NCPU; c++) begin
      rd(4'h8, 2'(c), d);
      check(req, d, cause_m[c]);
    end
  endtask

  task automatic check_irqs(input string req);
    logic [3:0] ei, em;
    @(negedge clk);
    for (int c = 0; c < NCPU; c++) begin
      ei[c] = |(cause_m[c][7:0] & mask_m[c][7:0]);
      em[c] = |(cause_m[c][31:16] & mask_m[c][31:16]);
    end
    check({req, " ipi"}, {28'd0, ipi_irq}, {28'd0, ei});
    check({req, " msi"}, {28'd0, msi_irq}, {28'd0, em});
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCPU; c++) wr(4'h8, 2'(c), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NCPU; c++) begin cause_m[c] = '0; mask_m[c] = '0; end
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 ipi", {28'd0, ipi_irq}, 32'd0);
    check("R1 msi", {28'd0, msi_irq}, 32'd0);
    check_causes("R1 cause");
    for (int c = 0; c < NCPU; c++) begin
      rd(4'hC, 2'(c), d);
      check("R1 mask", d, 32'd0);
    end

    // R2/R3: every doorbell x every target map, ignored bits filled
    for (int n = 0; n < 32; n++)
      for (int t = 0; t < 16; t++) begin
        clear_all();
        wr(4'h4, 2'(t % 4), {8'hA5 ^ 8'(n), 4'(t + n), 4'(t), 3'(n * 3), 5'(n)});
        check_causes("R2 trigger decode");
      end

    // R3: only nonexistent target bits set -> nothing latched
    clear_all();
    wr(4'h4, 2'd0, 32'h00FF_F003);
    check_causes("R3 ghost targets");

    // R4: inbound message word raises 16+k everywhere
    for (int k = 0; k < 16; k++) begin
      clear_all();
      msi(32'hF00 | (16 + k));
      check_causes("R4 msi word");
    end

    // R5: clear-by-zero, per-CPU isolation
    clear_all();
    msi(32'hF03); msi(32'hF15); msi(32'hF1F); wr(4'h4, 2'd0, 32'h0000_0F09);
    wr(4'h8, 2'd2, 32'hFFFF_FFF7);
    check_causes("R5 partial clear");
    wr(4'h8, 2'd1, 32'h8000_0008);
    check_causes("R5 keep ones");
    wr(4'h8, 2'd3, 32'd0);
    check_causes("R5 clear all");

    // R6: enable registers per requester, readable
    for (int c = 0; c < NCPU; c++) wr(4'hC, 2'(c), 32'h1234_5678 ^ (32'h1111_1111 * c));
    for (int c = 0; c < NCPU; c++) begin
      rd(4'hC, 2'(c), d);
      check("R6 mask readback", d, mask_m[c]);
    end

    // R7/R8/R9: summary ranges with all enabled, then none
    for (int c = 0; c < NCPU; c++) wr(4'hC, 2'(c), 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      clear_all();
      check_irqs("R7 R8 idle");
      wr(4'h4, 2'd1, 32'h0000_0F00 | n);
      check_irqs(n < 8 ? "R7 ipi range" : (n < 16 ? "R9 gap" : "R8 msi range"));
    end
    for (int c = 0; c < NCPU; c++) wr(4'hC, 2'(c), 32'd0);
    check_irqs("R6 R7 disabled");
    wr(4'hC, 2'd2, 32'h0001_0080);
    check_irqs("R7 R8 single enable");
    wr(4'hC, 2'd2, 32'h0000_FF00);
    check_irqs("R9 gap enabled only");

    // R10: clear and set on the same bit in the same cycle
    clear_all();
    msi(32'hF14);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 4'h8; bus_cpu = 2'd0; bus_wdata = 32'd0;
    msi_wr = 1; msi_data = 32'h0000_0114;
    @(negedge clk);
    bus_en = 0; bus_we = 0; msi_wr = 0;
    cause_m[0] = 32'h0010_0000;
    check_causes("R10 msi beats clear");
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 4'h8; bus_cpu = 2'd1; bus_wdata = 32'd0;
    msi_wr = 1; msi_data = 32'h0000_0205;
    @(negedge clk);
    bus_en = 0; bus_we = 0; msi_wr = 0;
    cause_m[1] = 32'h0000_0020;
    check_causes("R10 clear vs other bit");

    // R11: read timing, unmapped offsets, hold
    rd(4'h4, 2'd0, d);
    check("R11 trig reads zero", d, 32'd0);
    rd(4'h8, 2'd1, d);
    check("R11 cause read", d, cause_m[1]);
    repeat (3) @(negedge clk);
    check("R11 hold", bus_rdata, cause_m[1]);
    rd(4'h0, 2'd1, d);
    check("R11 offset zero", d, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule